// File: doc/BRIEF.md
# Address Translation Window Unit

This block holds a bank of address translation windows for a root-port bridge, split into two directions: outbound (requests leaving the host towards the link) and inbound (requests arriving from the link). Software reaches all windows through one indirect viewport. A select register picks a direction and a window index, and one shared set of control, base, limit and target registers then reads and writes that window only.

Each window is either a memory window or a configuration window. On a lookup, every enabled window of the requested direction compares the incoming address against its inclusive range. When a memory window hits, the result is the address rebased onto the window's target. When a configuration window hits, the result is a bus number, a device/function number and a register offset. The lowest-indexed matching window wins. A miss returns the address unchanged and clears the hit flag. Register writes only stage new settings. The settings that the lookup logic uses are captured when the second control register is written, so a window can be reprogrammed field by field without passing through partial states.

Top module: `atw_top`

## Requirements
- R1: After reset the viewport selects outbound window 0. Every window reads back base 0, target 0, limit 0xFFFFFFFF, control-1 0 and control-2 0, except inbound window 0, whose control-2 reads 0x80000000. `rs_valid` and `rs_hit` are 0.
- R2: The viewport register sits at offset 0x900. Bit 31 selects inbound (1) or outbound (0), and bits [IDX_W-1:0] select the window index. A write keeps only those bits, and a read returns them with every other bit 0.
- R3: The per-window registers are control-1 at 0x904, control-2 at 0x908, base low/high at 0x90C/0x910, limit at 0x914 and target low/high at 0x918/0x91C. They read and write the window that the viewport currently selects, and each window keeps its own values.
- R4: Out of reset, inbound window 0 is active as an identity memory window over 0..0xFFFFFFFF. Every inbound address in that range hits window 0 and comes back unchanged.
- R5: Writes to control-1, base, limit or target do not change lookup results until control-2 of that window is written. Writing control-2 captures enable = bit 31, type, base, limit and target.
- R6: A window hits when it is enabled and base <= A <= limit, with the 32-bit limit zero-extended. A memory window (captured control-1 equal to 0) returns `rs_addr` = target + (A - base) with `rs_cfg`, `rs_bus`, `rs_devfn` and `rs_cfg_off` all 0.
- R7: A configuration window (captured control-1 not 0) sets `rs_cfg`. It returns `rs_bus` = target[31:24], `rs_devfn` = target[23:16] and `rs_cfg_off` = (A - base) mod 4096, and `rs_addr` = A.
- R8: When several windows of the same direction hit, the one with the lowest index wins, and `rs_win` reports that index.
- R9: On a miss, `rs_hit` = 0, `rs_addr` = A, and `rs_cfg`, `rs_win`, `rs_bus`, `rs_devfn` and `rs_cfg_off` are 0.
- R10: A lookup only considers windows of the direction given by `lk_inbound`.
- R11: A lookup presented with `lk_valid` in one cycle yields its result on the next clock edge. `rs_valid` is high for exactly that one cycle, and the result outputs hold their values until the next lookup.
- R12: Writes to offsets outside 0x900..0x91C change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_inbound | input | 1 | Lookup direction: 1 inbound, 0 outbound |
| lk_addr | input | 64 | Address to translate |
| rs_valid | output | 1 | Result valid, one cycle after `lk_valid` |
| rs_hit | output | 1 | A window matched |
| rs_cfg | output | 1 | Matching window is a configuration window |
| rs_win | output | IDX_W | Index of the matching window |
| rs_addr | output | 64 | Translated or passed-through address |
| rs_bus | output | 8 | Configuration bus number |
| rs_devfn | output | 8 | Configuration device/function number |
| rs_cfg_off | output | 12 | Configuration register offset |

## Verification
The bench builds the unit with four windows per direction. At that size every window index, the two-bit viewport mask and every overlap priority between neighbouring windows can be reached in a short run. The bench programs overlapping memory windows, configuration windows, a disabled window and a window whose base lies above its limit. It then sweeps both directions across the whole programmed address region in fine steps, adds the exact edges of every window, and compares each result with an arithmetic model of the requirements. Staged-but-uncommitted edits and the read-back of every register of all eight windows are covered as well.

// File: rtl/atw_pkg.sv
package atw_pkg;

  localparam int ADDR_W  = 64;
  localparam int LIMIT_W = 32;
  localparam int REG_W   = 32;
  localparam int OFS_W   = 12;

  localparam logic [OFS_W-1:0] OFS_VIEW    = 12'h900;
  localparam logic [OFS_W-1:0] OFS_CTL1    = 12'h904;
  localparam logic [OFS_W-1:0] OFS_CTL2    = 12'h908;
  localparam logic [OFS_W-1:0] OFS_BASE_LO = 12'h90C;
  localparam logic [OFS_W-1:0] OFS_BASE_HI = 12'h910;
  localparam logic [OFS_W-1:0] OFS_LIMIT   = 12'h914;
  localparam logic [OFS_W-1:0] OFS_TGT_LO  = 12'h918;
  localparam logic [OFS_W-1:0] OFS_TGT_HI  = 12'h91C;

  localparam int DIR_OUT = 0;
  localparam int DIR_IN  = 1;

  // staged (software-visible) copy of a window
  typedef struct packed {
    logic [REG_W-1:0]   ctl1;
    logic [REG_W-1:0]   ctl2;
    logic [ADDR_W-1:0]  base;
    logic [LIMIT_W-1:0] limit;
    logic [ADDR_W-1:0]  target;
  } win_stage_t;

  // committed copy used by the lookup path
  typedef struct packed {
    logic               en;
    logic               is_cfg;
    logic [ADDR_W-1:0]  base;
    logic [LIMIT_W-1:0] limit;
    logic [ADDR_W-1:0]  target;
  } win_live_t;

  function automatic win_stage_t stage_reset(input logic pass_all);
    win_stage_t s;
    s.ctl1   = '0;
    s.ctl2   = pass_all ? 32'h8000_0000 : 32'h0;
    s.base   = '0;
    s.limit  = '1;
    s.target = '0;
    return s;
  endfunction

  function automatic win_live_t live_reset(input logic pass_all);
    win_live_t l;
    l.en     = pass_all;
    l.is_cfg = 1'b0;
    l.base   = '0;
    l.limit  = '1;
    l.target = '0;
    return l;
  endfunction

endpackage

// File: rtl/atw_regfile.sv
module atw_regfile
  import atw_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [OFS_W-1:0]             addr_i,
  input  logic [REG_W-1:0]             wdata_i,
  output logic [REG_W-1:0]             rdata_o,
  output win_live_t [NUM_WIN-1:0]      live_out_o,
  output win_live_t [NUM_WIN-1:0]      live_in_o
);

  win_stage_t [1:0][NUM_WIN-1:0] stg_q, stg_d;
  win_live_t  [1:0][NUM_WIN-1:0] live_q, live_d;
  logic                          vp_dir_q, vp_dir_d;
  logic [IDX_W-1:0]              vp_idx_q, vp_idx_d;
  win_stage_t                    cur;

  assign cur = stg_q[vp_dir_q][vp_idx_q];

  // next-state: decode one register write against the selected window
  always_comb begin
    stg_d    = stg_q;
    live_d   = live_q;
    vp_dir_d = vp_dir_q;
    vp_idx_d = vp_idx_q;
    unique case (addr_i)
      OFS_VIEW: begin
        vp_dir_d = wdata_i[31];
        vp_idx_d = wdata_i[IDX_W-1:0];
      end
      OFS_CTL1:    stg_d[vp_dir_q][vp_idx_q].ctl1 = wdata_i;
      OFS_CTL2: begin
        stg_d[vp_dir_q][vp_idx_q].ctl2    = wdata_i;
        live_d[vp_dir_q][vp_idx_q].en     = wdata_i[31];
        live_d[vp_dir_q][vp_idx_q].is_cfg = (cur.ctl1 != '0);
        live_d[vp_dir_q][vp_idx_q].base   = cur.base;
        live_d[vp_dir_q][vp_idx_q].limit  = cur.limit;
        live_d[vp_dir_q][vp_idx_q].target = cur.target;
      end
      OFS_BASE_LO: stg_d[vp_dir_q][vp_idx_q].base[31:0]    = wdata_i;
      OFS_BASE_HI: stg_d[vp_dir_q][vp_idx_q].base[63:32]   = wdata_i;
      OFS_LIMIT:   stg_d[vp_dir_q][vp_idx_q].limit         = wdata_i;
      OFS_TGT_LO:  stg_d[vp_dir_q][vp_idx_q].target[31:0]  = wdata_i;
      OFS_TGT_HI:  stg_d[vp_dir_q][vp_idx_q].target[63:32] = wdata_i;
      default: ;
    endcase
  end

  // registers, enabled by the write strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vp_dir_q <= 1'b0;
      vp_idx_q <= '0;
      for (int d = 0; d < 2; d++) begin
        for (int w = 0; w < NUM_WIN; w++) begin
          stg_q[d][w]  <= stage_reset(d == DIR_IN && w == 0);
          live_q[d][w] <= live_reset(d == DIR_IN && w == 0);
        end
      end
    end else if (we_i) begin
      vp_dir_q <= vp_dir_d;
      vp_idx_q <= vp_idx_d;
      stg_q    <= stg_d;
      live_q   <= live_d;
    end
  end

  // read mux
  always_comb begin
    unique case (addr_i)
      OFS_VIEW:    rdata_o = {vp_dir_q, {(31-IDX_W){1'b0}}, vp_idx_q};
      OFS_CTL1:    rdata_o = cur.ctl1;
      OFS_CTL2:    rdata_o = cur.ctl2;
      OFS_BASE_LO: rdata_o = cur.base[31:0];
      OFS_BASE_HI: rdata_o = cur.base[63:32];
      OFS_LIMIT:   rdata_o = cur.limit;
      OFS_TGT_LO:  rdata_o = cur.target[31:0];
      OFS_TGT_HI:  rdata_o = cur.target[63:32];
      default:     rdata_o = '0;
    endcase
  end

  assign live_out_o = live_q[DIR_OUT];
  assign live_in_o  = live_q[DIR_IN];

  // R5: lookup settings move only on a control-2 write
  a_r5_live_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == OFS_CTL2) |=> $stable(live_q));

  // R12: writes outside the window block leave all state alone
  a_r12_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i < OFS_VIEW || addr_i > OFS_TGT_HI)) |=>
      ($stable(stg_q) && $stable(vp_idx_q) && $stable(vp_dir_q)));

endmodule

// File: rtl/atw_match.sv
module atw_match
  import atw_pkg::*;
#(
  parameter int NUM_WIN = 4,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  win_live_t [NUM_WIN-1:0] live_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic                    hit_o,
  output logic [IDX_W-1:0]        idx_o,
  output win_live_t               win_o
);

  logic [NUM_WIN-1:0] hv;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    assign hv[w] = live_i[w].en &&
                   (addr_i >= live_i[w].base) &&
                   (addr_i <= {{(ADDR_W-LIMIT_W){1'b0}}, live_i[w].limit});
  end

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hv[w]) idx_o = IDX_W'(w);
    end
  end

  assign hit_o = |hv;
  assign win_o = live_i[idx_o];

  // R8: the chosen window hits and no lower-indexed one does
  a_r8_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (hv[idx_o] && ((hv & ~({NUM_WIN{1'b1}} << idx_o)) == '0)));

  // R9: no hit reported when nothing matches
  a_r9_no_false_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hv == '0) |-> !hit_o);

endmodule

// File: rtl/atw_xlat.sv
module atw_xlat
  import atw_pkg::*;
#(
  parameter int IDX_W     = 2,
  parameter int CFG_OFF_W = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 hit_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  win_live_t            win_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 valid_o,
  output logic                 hit_o,
  output logic                 cfg_o,
  output logic [IDX_W-1:0]     win_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [7:0]           bus_o,
  output logic [7:0]           devfn_o,
  output logic [CFG_OFF_W-1:0] cfg_off_o
);

  logic [ADDR_W-1:0]    rel;
  logic                 cfg_d;
  logic [IDX_W-1:0]     win_d;
  logic [ADDR_W-1:0]    addr_d;
  logic [7:0]           bus_d, devfn_d;
  logic [CFG_OFF_W-1:0] off_d;

  assign rel = addr_i - win_i.base;

  always_comb begin
    cfg_d   = 1'b0;
    win_d   = '0;
    addr_d  = addr_i;
    bus_d   = '0;
    devfn_d = '0;
    off_d   = '0;
    if (hit_i) begin
      win_d = idx_i;
      if (win_i.is_cfg) begin
        cfg_d   = 1'b1;
        bus_d   = win_i.target[31:24];
        devfn_d = win_i.target[23:16];
        off_d   = rel[CFG_OFF_W-1:0];
      end else begin
        addr_d  = win_i.target + rel;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      hit_o     <= 1'b0;
      cfg_o     <= 1'b0;
      win_o     <= '0;
      addr_o    <= '0;
      bus_o     <= '0;
      devfn_o   <= '0;
      cfg_off_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        hit_o     <= hit_i;
        cfg_o     <= cfg_d;
        win_o     <= win_d;
        addr_o    <= addr_d;
        bus_o     <= bus_d;
        devfn_o   <= devfn_d;
        cfg_off_o <= off_d;
      end
    end
  end

  // R11: one result pulse per lookup, one cycle later
  a_r11_pulse_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r11_pulse_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(addr_o) && $stable(hit_o)));

  // R9: a miss passes the address straight through
  a_r9_miss_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !hit_i) |=> (!hit_o && !cfg_o && addr_o == $past(addr_i)));

  // R7: a config result always comes from a hit
  a_r7_cfg_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cfg_o) |-> hit_o);

endmodule

// File: rtl/atw_top.sv
module atw_top
  import atw_pkg::*;
#(
  parameter int NUM_WIN   = 4,
  parameter int CFG_OFF_W = 12,
  localparam int IDX_W    = $clog2(NUM_WIN)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [11:0]          reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 lk_valid,
  input  logic                 lk_inbound,
  input  logic [63:0]          lk_addr,
  output logic                 rs_valid,
  output logic                 rs_hit,
  output logic                 rs_cfg,
  output logic [IDX_W-1:0]     rs_win,
  output logic [63:0]          rs_addr,
  output logic [7:0]           rs_bus,
  output logic [7:0]           rs_devfn,
  output logic [CFG_OFF_W-1:0] rs_cfg_off
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  win_live_t [1:0][NUM_WIN-1:0] live;
  logic      [1:0]              dir_hit;
  logic      [1:0][IDX_W-1:0]   dir_idx;
  win_live_t [1:0]              dir_win;

  atw_regfile #(.NUM_WIN(NUM_WIN)) u_regs (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .we_i       (reg_we),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .rdata_o    (reg_rdata),
    .live_out_o (live[DIR_OUT]),
    .live_in_o  (live[DIR_IN])
  );

  for (genvar d = 0; d < 2; d++) begin : g_dir
    atw_match #(.NUM_WIN(NUM_WIN)) u_match (
      .clk_i  (clk),
      .rst_ni (rst_ni),
      .live_i (live[d]),
      .addr_i (lk_addr),
      .hit_o  (dir_hit[d]),
      .idx_o  (dir_idx[d]),
      .win_o  (dir_win[d])
    );
  end

  atw_xlat #(.IDX_W(IDX_W), .CFG_OFF_W(CFG_OFF_W)) u_xlat (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .valid_i   (lk_valid),
    .hit_i     (dir_hit[lk_inbound]),
    .idx_i     (dir_idx[lk_inbound]),
    .win_i     (dir_win[lk_inbound]),
    .addr_i    (lk_addr),
    .valid_o   (rs_valid),
    .hit_o     (rs_hit),
    .cfg_o     (rs_cfg),
    .win_o     (rs_win),
    .addr_o    (rs_addr),
    .bus_o     (rs_bus),
    .devfn_o   (rs_devfn),
    .cfg_off_o (rs_cfg_off)
  );

endmodule

// File: tb/atw_top_tb_top.sv
module atw_top_tb_top;

  localparam int NW = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [11:0]   reg_addr;
  logic [31:0]   reg_wdata;
  logic [31:0]   reg_rdata;
  logic          lk_valid;
  logic          lk_inbound;
  logic [63:0]   lk_addr;
  logic          rs_valid, rs_hit, rs_cfg;
  logic [IW-1:0] rs_win;
  logic [63:0]   rs_addr;
  logic [7:0]    rs_bus, rs_devfn;
  logic [11:0]   rs_cfg_off;

  always #2 clk = ~clk;

  atw_top #(.NUM_WIN(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_inbound(lk_inbound), .lk_addr(lk_addr), .rs_valid(rs_valid),
    .rs_hit(rs_hit), .rs_cfg(rs_cfg), .rs_win(rs_win), .rs_addr(rs_addr),
    .rs_bus(rs_bus), .rs_devfn(rs_devfn), .rs_cfg_off(rs_cfg_off)
  );

  int n_vec = 0;
  int n_bad = 0;

  // bench model: staged and committed window settings
  logic [31:0] s_ctl1 [2][NW];
  logic [31:0] s_ctl2 [2][NW];
  logic [63:0] s_base [2][NW];
  logic [31:0] s_lim  [2][NW];
  logic [63:0] s_tgt  [2][NW];
  logic        m_en   [2][NW];
  logic        m_cfg  [2][NW];
  logic [63:0] m_base [2][NW];
  logic [31:0] m_lim  [2][NW];
  logic [63:0] m_tgt  [2][NW];
  int sel_d = 0;
  int sel_i = 0;

  task automatic model_reset();
    for (int d = 0; d < 2; d++) begin
      for (int w = 0; w < NW; w++) begin
        s_ctl1[d][w] = 0; s_ctl2[d][w] = (d == 1 && w == 0) ? 32'h8000_0000 : 0;
        s_base[d][w] = 0; s_lim[d][w] = 32'hFFFF_FFFF; s_tgt[d][w] = 0;
        m_en[d][w] = (d == 1 && w == 0); m_cfg[d][w] = 0;
        m_base[d][w] = 0; m_lim[d][w] = 32'hFFFF_FFFF; m_tgt[d][w] = 0;
      end
    end
    sel_d = 0; sel_i = 0;
  endtask

  task automatic chk32(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    case (a)
      12'h900: begin sel_d = int'(d[31]); sel_i = int'(d[IW-1:0]); end
      12'h904: s_ctl1[sel_d][sel_i] = d;
      12'h908: begin
        s_ctl2[sel_d][sel_i] = d;
        m_en[sel_d][sel_i]   = d[31];
        m_cfg[sel_d][sel_i]  = (s_ctl1[sel_d][sel_i] != 0);
        m_base[sel_d][sel_i] = s_base[sel_d][sel_i];
        m_lim[sel_d][sel_i]  = s_lim[sel_d][sel_i];
        m_tgt[sel_d][sel_i]  = s_tgt[sel_d][sel_i];
      end
      12'h90C: s_base[sel_d][sel_i][31:0]  = d;
      12'h910: s_base[sel_d][sel_i][63:32] = d;
      12'h914: s_lim[sel_d][sel_i]         = d;
      12'h918: s_tgt[sel_d][sel_i][31:0]   = d;
      12'h91C: s_tgt[sel_d][sel_i][63:32]  = d;
      default: ;
    endcase
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rdchk(string req, logic [11:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk32(req, $sformatf("reg %h", a), v, exp);
  endtask

  task automatic sel(bit ib, int idx);
    wr(12'h900, (ib ? 32'h8000_0000 : 32'h0) | 32'(idx));
  endtask

  task automatic prog(bit ib, int idx, logic [63:0] base, logic [31:0] lim,
                      logic [63:0] tgt, logic [31:0] c1, logic [31:0] c2);
    sel(ib, idx);
    wr(12'h90C, base[31:0]); wr(12'h910, base[63:32]);
    wr(12'h914, lim);
    wr(12'h918, tgt[31:0]);  wr(12'h91C, tgt[63:32]);
    wr(12'h904, c1);
    wr(12'h908, c2);
  endtask

  // R6 R7 R8 R9 R10: expected lookup result from the requirements
  task automatic look(string req, bit ib, logic [63:0] a);
    logic e_hit, e_cfg;
    logic [IW-1:0] e_win;
    logic [63:0] e_addr;
    logic [7:0] e_bus, e_dfn;
    logic [11:0] e_off;
    int d;
    d = ib ? 1 : 0;
    e_hit = 0; e_cfg = 0; e_win = 0; e_addr = a; e_bus = 0; e_dfn = 0; e_off = 0;
    for (int w = NW - 1; w >= 0; w--) begin
      if (m_en[d][w] && a >= m_base[d][w] && a <= {32'h0, m_lim[d][w]}) begin
        e_hit = 1; e_win = IW'(w);
        if (m_cfg[d][w]) begin
          e_cfg = 1; e_addr = a;
          e_bus = m_tgt[d][w][31:24]; e_dfn = m_tgt[d][w][23:16];
          e_off = 12'((a - m_base[d][w]) & 64'hFFF);
        end else begin
          e_cfg = 0; e_bus = 0; e_dfn = 0; e_off = 0;
          e_addr = m_tgt[d][w] + (a - m_base[d][w]);
        end
      end
    end
    @(negedge clk);
    lk_valid = 1'b1; lk_inbound = ib; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    n_vec++;
    if (rs_valid !== 1'b1 || rs_hit !== e_hit || rs_cfg !== e_cfg || rs_win !== e_win ||
        rs_addr !== e_addr || rs_bus !== e_bus || rs_devfn !== e_dfn || rs_cfg_off !== e_off) begin
      n_bad++;
      $display("FAIL %s dir=%0d A=%h: got v%0b h%0b c%0b w%0d a=%h b=%h f=%h o=%h expected v1 h%0b c%0b w%0d a=%h b=%h f=%h o=%h",
               req, d, a, rs_valid, rs_hit, rs_cfg, rs_win, rs_addr, rs_bus, rs_devfn, rs_cfg_off,
               e_hit, e_cfg, e_win, e_addr, e_bus, e_dfn, e_off);
    end
  endtask

  task automatic edges(bit ib);
    int d;
    d = ib ? 1 : 0;
    for (int w = 0; w < NW; w++) begin
      look("R6 R8 edge", ib, m_base[d][w] - 1);
      look("R6 R8 edge", ib, m_base[d][w]);
      look("R6 R8 edge", ib, m_base[d][w] + 1);
      look("R6 R8 edge", ib, {32'h0, m_lim[d][w]} - 1);
      look("R6 R8 edge", ib, {32'h0, m_lim[d][w]});
      look("R6 R8 edge", ib, {32'h0, m_lim[d][w]} + 1);
    end
    look("R9 far", ib, 64'hFFFF_FFFF_FFFF_FFFF);
    look("R9 far", ib, 64'h1_0000_0000);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    reg_we = 0; reg_addr = 0; reg_wdata = 0;
    lk_valid = 0; lk_inbound = 0; lk_addr = 0;
    rst_n = 1'b0;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk32("R1", "rs_valid", {31'h0, rs_valid}, 32'h0);
    chk32("R1", "rs_hit", {31'h0, rs_hit}, 32'h0);
    rdchk("R1", 12'h900, 32'h0);
    rdchk("R1", 12'h904, 32'h0);
    rdchk("R1", 12'h908, 32'h0);
    rdchk("R1", 12'h90C, 32'h0);
    rdchk("R1", 12'h910, 32'h0);
    rdchk("R1", 12'h914, 32'hFFFF_FFFF);
    rdchk("R1", 12'h918, 32'h0);
    rdchk("R1", 12'h91C, 32'h0);
    sel(1, 0);
    rdchk("R1", 12'h908, 32'h8000_0000);

    // R4: inbound pass-all window; R10 outbound sees nothing
    look("R4", 1, 64'h0);
    look("R4", 1, 64'h1234_5678);
    look("R4", 1, 64'hFFFF_FFFF);
    look("R4 R9", 1, 64'h1_0000_0000);
    look("R10", 0, 64'h100);

    // R11: result pulse lasts one cycle and outputs hold
    look("R11", 1, 64'h55);
    @(negedge clk);
    chk32("R11", "rs_valid idle", {31'h0, rs_valid}, 32'h0);
    chk32("R11", "rs_addr hold", rs_addr[31:0], 32'h55);

    // R2: viewport masking
    wr(12'h900, 32'hFFFF_FFFF);
    rdchk("R2", 12'h900, 32'h8000_0003);
    wr(12'h900, 32'h1234_5675);
    rdchk("R2", 12'h900, 32'h0000_0001);

    // R12: stray offsets
    sel(0, 0);
    wr(12'h8FC, 32'hFFFF_FFFF);
    wr(12'h920, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    rdchk("R12", 12'h8FC, 32'h0);
    rdchk("R12", 12'h920, 32'h0);
    rdchk("R12", 12'h900, 32'h0);
    rdchk("R12", 12'h914, 32'hFFFF_FFFF);
    rdchk("R12", 12'h908, 32'h0);
    look("R12", 1, 64'h77);

    // program both directions
    prog(0, 0, 64'h1000,  32'h1FFF,  64'h8_0000_0000, 32'h0, 32'h8000_0000);
    prog(0, 1, 64'h1800,  32'h2FFF,  64'h4000,        32'h0, 32'h8000_0000);
    prog(0, 2, 64'h10000, 32'h1FFFF, 64'h0312_0000,   32'h4, 32'h8000_0000);
    prog(0, 3, 64'h40000, 32'h4FFFF, 64'h9_0000,      32'h0, 32'h0);
    prog(1, 0, 64'h2000,  32'h2FFF,  64'h1_0000_0000, 32'h0, 32'h8000_0000);
    prog(1, 1, 64'h0,     32'h0FFF,  64'hAB_CD_0000,  32'h1, 32'h8000_0001);
    prog(1, 2, 64'h1_0000_0000, 32'hFFFF_FFFF, 64'h7, 32'h0, 32'h8000_0000);
    prog(1, 3, 64'h0,     32'hFFFF_FFFF, 64'h100,     32'h0, 32'h0);

    // R3: read back every register of every window
    for (int d = 0; d < 2; d++) begin
      for (int w = 0; w < NW; w++) begin
        sel(d == 1, w);
        rdchk("R3", 12'h904, s_ctl1[d][w]);
        rdchk("R3", 12'h908, s_ctl2[d][w]);
        rdchk("R3", 12'h90C, s_base[d][w][31:0]);
        rdchk("R3", 12'h910, s_base[d][w][63:32]);
        rdchk("R3", 12'h914, s_lim[d][w]);
        rdchk("R3", 12'h918, s_tgt[d][w][31:0]);
        rdchk("R3", 12'h91C, s_tgt[d][w][63:32]);
      end
    end

    // R6 R7 R8 R9 R10: sweep both directions
    for (int d = 0; d < 2; d++) begin
      for (int a = 0; a <= 32'h50000; a += 32'h100) begin
        look("R6 R7 R8 R10 sweep", d == 1, 64'(a));
      end
      for (int a = 32'h10F00; a <= 32'h11100; a += 32'h13) begin
        look("R7 offset", d == 1, 64'(a));
      end
      edges(d == 1);
    end

    // R5: staged edits take effect only on control-2
    sel(0, 1);
    wr(12'h90C, 32'h0);
    wr(12'h904, 32'h1);
    rdchk("R5", 12'h90C, 32'h0);
    look("R5 staged", 0, 64'h800);
    look("R5 staged", 0, 64'h2800);
    wr(12'h908, 32'h8000_0000);
    look("R5 commit", 0, 64'h800);
    look("R5 commit", 0, 64'h2800);
    look("R5 commit R8", 0, 64'h1800);
    wr(12'h908, 32'h0);
    look("R5 disable", 0, 64'h800);
    look("R5 disable", 0, 64'h2800);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule